// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital front end of a single-channel serial digital-to-analog converter. A host drives an active-low select line, a serial clock and a serial data line. While select is low, the block shifts in one bit on every rising serial-clock edge. When select returns high, the block decodes the captured frame and runs its command against a pair of registers: a staging register and the converter register that drives the analog stage.

A frame carries a 4-bit command, then four ignored bits, then a 16-bit data word whose top bits hold the code, most significant bit first. The block keeps only the most recent 24 bits. A host that pads frames to 32 bits by sending eight leading filler bits therefore works without any setting. The staging register lets a host load a new code and apply it later. A power-down command disables the output but keeps the converter code.

The three serial lines are brought into the system clock domain through synchronizer flops. Their edges are found there, so all the state of the block lives in a single clock domain.

Top module: `sdac_iface`

## Requirements
- R1: After synchronous reset, `dac_code` is 0, `out_en` is 1 and the staging register is 0.
- R2: Command 4'b0000 (write) loads the code into the staging register and leaves `dac_code` unchanged. The code sits in frame bits [15:6], counted from the last bit shifted, which is bit 0. Frame bits [23:20] are the command, sent first.
- R3: Command 4'b0001 (update) copies the staging register to `dac_code`.
- R4: Command 4'b0011 (write-and-update) loads the code into both registers in one frame.
- R5: Command 4'b0100 (power-down) clears `out_en`. `dac_code` and the staging register keep their values while powered down.
- R6: An update or a write-and-update sets `out_en` again.
- R7: If select rises after fewer than 24 rising serial-clock edges, the frame is dropped and neither register changes.
- R8: For frames of more than 24 bits (32, 40, ...), only the last 24 bits shifted in are decoded.
- R9: Command codes other than 0000, 0001, 0011 and 0100 change neither register nor `out_en`.
- R10: Serial-clock edges and data while select is high have no effect.
- R11: Frame bits [19:16] and [5:0] are ignored.
- R12: A command runs only after select rises. Completing 24 edges with select still low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select; its rising edge runs the command |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edges |
| ser_din | input | 1 | Serial data, MSB of frame first |
| dac_code | output | CODE_W | Converter register code |
| out_en | output | 1 | High when the converter is powered up |

## Verification
The staging register has no port of its own, so a wrong value there shows only at the next update. Each check on it is therefore a write followed by an update, and the code comes out a few cycles after the second select rise. Bit-count or shift-alignment faults show as a wrong `dac_code` a few system cycles after the select rise that ends the affected frame. An exhaustive sweep over all 1024 codes, with varied filler bits, exposes any mis-slice of the code. A power-state fault shows at once in `out_en` after the power-down or update frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_BITS = 24;
  localparam int WORD_BITS  = 16;
  localparam int CMD_BITS   = 4;

  localparam logic [CMD_BITS-1:0] CMD_WRITE  = 4'b0000;
  localparam logic [CMD_BITS-1:0] CMD_UPDATE = 4'b0001;
  localparam logic [CMD_BITS-1:0] CMD_WRUPD  = 4'b0011;
  localparam logic [CMD_BITS-1:0] CMD_PDOWN  = 4'b0100;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= RST_VAL;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_s,
  input  logic                  sclk_s,
  input  logic                  din_s,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  sel_rise,
  output logic                  load_evt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic sel_q, sclk_q;
  logic sel_fall, sclk_rise;

  assign sel_fall  = sel_q & ~sel_s;
  assign sel_rise  = ~sel_q & sel_s;
  assign sclk_rise = ~sclk_q & sclk_s;
  assign load_evt  = sel_rise && (bit_cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b1;
      sclk_q  <= 1'b0;
      frame   <= '0;
      bit_cnt <= '0;
    end else begin
      sel_q  <= sel_s;
      sclk_q <= sclk_s;
      if (sel_fall) begin
        bit_cnt <= '0;
      end else if (!sel_s && sclk_rise) begin
        frame <= {frame[FRAME_BITS-2:0], din_s};
        if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdac_exec.sv
module sdac_exec
  import sdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_evt,
  input  logic [FRAME_BITS-1:0] frame,
  output logic [CODE_W-1:0]     dac_code,
  output logic                  out_en
);
  logic [CMD_BITS-1:0] cmd;
  logic [CODE_W-1:0]   code_in;
  logic [CODE_W-1:0]   stage_q;

  assign cmd     = frame[FRAME_BITS-1 -: CMD_BITS];
  assign code_in = frame[WORD_BITS-1 -: CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      dac_code <= '0;
      out_en   <= 1'b1;
    end else if (load_evt) begin
      case (cmd)
        CMD_WRITE:  stage_q <= code_in;
        CMD_UPDATE: begin
          dac_code <= stage_q;
          out_en   <= 1'b1;
        end
        CMD_WRUPD: begin
          stage_q  <= code_in;
          dac_code <= code_in;
          out_en   <= 1'b1;
        end
        CMD_PDOWN:  out_en <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdac_iface.sv
module sdac_iface
  import sdac_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [CODE_W-1:0] dac_code,
  output logic              out_en
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [2:0]            sync_q;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  sel_rise, load_evt;
  logic [CMD_BITS-1:0]   cmd;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({sel_n, ser_clk, ser_din}), .q(sync_q)
  );

  sdac_shift #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .sel_s(sync_q[2]), .sclk_s(sync_q[1]),
    .din_s(sync_q[0]), .frame(frame), .bit_cnt(bit_cnt),
    .sel_rise(sel_rise), .load_evt(load_evt)
  );

  sdac_exec #(.CODE_W(CODE_W)) u_exec (
    .clk(clk), .rst(rst), .load_evt(load_evt), .frame(frame),
    .dac_code(dac_code), .out_en(out_en)
  );

  assign cmd = frame[FRAME_BITS-1 -: CMD_BITS];
endmodule

// File: rtl/sdac_iface_chk.sv
module sdac_iface_chk
  import sdac_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_rise,
  input logic              load_evt,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CMD_BITS-1:0] cmd,
  input logic [CODE_W-1:0] dac_code,
  input logic              out_en
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && out_en));

  a_r12_code_moves_on_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> $past(load_evt));

  a_r7_short_discarded: assert property (@(posedge clk) disable iff (rst)
    (sel_rise && bit_cnt != FULL) |=> ($stable(dac_code) && $stable(out_en)));

  a_r8_cnt_limit: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL);

  a_r6_wake_on_update: assert property (@(posedge clk) disable iff (rst)
    (load_evt && (cmd == CMD_UPDATE || cmd == CMD_WRUPD)) |=> out_en);

  a_r5_pd_clears_en: assert property (@(posedge clk) disable iff (rst)
    (load_evt && cmd == CMD_PDOWN) |=> !out_en);

  a_r5_pd_holds_code: assert property (@(posedge clk) disable iff (rst)
    (!out_en && $past(!out_en)) |-> $stable(dac_code));
endmodule

bind sdac_iface sdac_iface_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sel_rise(sel_rise), .load_evt(load_evt),
  .bit_cnt(bit_cnt), .cmd(cmd), .dac_code(dac_code), .out_en(out_en)
);

// File: tb/sdac_iface_test.sv
module sdac_iface_test;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic [CW-1:0] dac_code;
  logic out_en;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdac_iface #(.CODE_W(CW)) uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .dac_code(dac_code), .out_en(out_en)
  );

  function automatic logic [23:0] mkf(logic [3:0] c, logic [CW-1:0] code, logic [9:0] dc);
    return {c, dc[9:6], code, dc[5:0]};
  endfunction

  task automatic wclk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bits(int n, logic [39:0] bits);
    for (int i = n - 1; i >= 0; i--) begin
      ser_clk = 1'b0; ser_din = bits[i]; wclk(2);
      ser_clk = 1'b1; wclk(2);
    end
    ser_clk = 1'b0; wclk(2);
  endtask

  task automatic xfer(int n, logic [39:0] bits);
    sel_n = 1'b0; wclk(3);
    shift_bits(n, bits);
    sel_n = 1'b1; wclk(8);
  endtask

  task automatic chk(string tag, logic [CW-1:0] ec, logic ee);
    n_chk++;
    if (dac_code !== ec || out_en !== ee) begin
      n_bad++;
      $display("FAIL %s: code=%h en=%b expected code=%h en=%b", tag, dac_code, out_en, ec, ee);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 190000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: code=%h en=%b expected completion", dac_code, out_en);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wclk(4); rst = 1'b0; wclk(2);
    chk("R1 reset", '0, 1'b1);
    // R1 staging register cleared: update shows 0
    xfer(24, {16'h0, mkf(4'b0001, 10'h155, 10'h0)});
    chk("R1 staging reset", '0, 1'b1);

    xfer(24, {16'h0, mkf(4'b0000, 10'h2A5, 10'h0)});
    chk("R2 write holds dac", '0, 1'b1);
    xfer(24, {16'h0, mkf(4'b0001, 10'h000, 10'h3FF)});
    chk("R3 update", 10'h2A5, 1'b1);

    // R4 R11 exhaustive code sweep with varied ignored bits
    for (int c = 0; c < 1024; c++) begin
      xfer(24, {16'h0, mkf(4'b0011, CW'(c), 10'((c * 37) ^ 10'h2B6))});
      chk("R4 R11 wr-upd sweep", CW'(c), 1'b1);
    end

    xfer(24, {16'h0, mkf(4'b0000, 10'h1C3, 10'h0)});
    chk("R2 write after sweep", 10'h3FF, 1'b1);
    xfer(24, {16'h0, mkf(4'b0100, 10'h000, 10'h0)});
    chk("R5 power-down", 10'h3FF, 1'b0);
    xfer(24, {16'h0, mkf(4'b0000, 10'h0F0, 10'h0)});
    chk("R5 write while down", 10'h3FF, 1'b0);
    xfer(24, {16'h0, mkf(4'b0001, 10'h000, 10'h0)});
    chk("R6 update wakes", 10'h0F0, 1'b1);
    xfer(24, {16'h0, mkf(4'b0100, 10'h000, 10'h0)});
    xfer(24, {16'h0, mkf(4'b0011, 10'h321, 10'h0)});
    chk("R6 wr-upd wakes", 10'h321, 1'b1);

    xfer(23, {16'h0, mkf(4'b0011, 10'h111, 10'h0)} >> 1);
    chk("R7 23-bit frame", 10'h321, 1'b1);
    xfer(0, 40'h0);
    chk("R7 empty frame", 10'h321, 1'b1);
    xfer(1, 40'h1);
    xfer(24, {16'h0, mkf(4'b0001, 10'h000, 10'h0)});
    chk("R7 staging intact", 10'h321, 1'b1);

    xfer(32, {8'hFF, mkf(4'b0011, 10'h2DB, 10'h0)});
    chk("R8 32-bit frame", 10'h2DB, 1'b1);
    xfer(40, {16'hA5C3, mkf(4'b0011, 10'h0A7, 10'h155)});
    chk("R8 40-bit frame", 10'h0A7, 1'b1);

    xfer(24, {16'h0, mkf(4'b0000, 10'h1EE, 10'h0)});
    for (int k = 0; k < 16; k++) begin
      if (k == 0 || k == 1 || k == 3 || k == 4) continue;
      xfer(24, {16'h0, mkf(4'(k), 10'(k * 61), 10'h0)});
      chk("R9 unused command", 10'h0A7, 1'b1);
    end
    xfer(24, {16'h0, mkf(4'b0001, 10'h000, 10'h0)});
    chk("R9 staging untouched", 10'h1EE, 1'b1);

    // R10 clock activity with select high
    for (int b = 0; b < 30; b++) begin
      ser_din = b[0] ^ b[2]; ser_clk = 1'b1; wclk(2); ser_clk = 1'b0; wclk(2);
    end
    wclk(6);
    chk("R10 idle clocks", 10'h1EE, 1'b1);

    // R12 no action until select rises
    sel_n = 1'b0; wclk(3);
    shift_bits(24, {16'h0, mkf(4'b0011, 10'h3A1, 10'h0)});
    wclk(10);
    chk("R12 select still low", 10'h1EE, 1'b1);
    sel_n = 1'b1; wclk(8);
    chk("R12 select risen", 10'h3A1, 1'b1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule